// File: doc/BRIEF.md
# Dual-Lane Simultaneous-Sampling ADC Reader

This block drives one eight-channel simultaneous-sampling converter whose results leave the chip on two serial data lanes. A start request in idle makes it pull the conversion-start line low for a set number of system clocks. It then waits for the converter's busy line to rise and afterwards to fall. Only once busy is low does it lower chip select and run the serial clock, shifting both lanes in on the same edges.

After one frame of 64 serial clocks, chip select is released. The eight 16-bit channel words are then presented together with a one-cycle valid strobe. During the frame the first-data indicator from the converter is compared against its required shape: high for the first word, low afterwards. Any other shape sets a sticky framing-error flag. If busy does not rise in time, or does not fall in time, the attempt is abandoned and a sticky timeout flag is set. Each converter gets its own instance.

Top module: `dual_lane_adc_reader`

## Requirements
- R1: While reset is applied and just after it: conv_n=1, cs_n=1, sclk=1, valid=0, frame_err=0, timeout_err=0.
- R2: A start request seen in idle drives conv_n low for exactly CONV_LOW system clocks. A start request outside idle is ignored: one request produces exactly one conv_n pulse and one frame.
- R3: cs_n goes low only after busy has risen and then fallen following the conv_n pulse. cs_n never falls while busy is high.
- R4: cs_n stays low for exactly 64*CLK_DIV system clocks, with exactly 64 serial clock periods inside. The sclk period is CLK_DIV system clocks, and sclk is high whenever cs_n is high.
- R5: Both lanes are sampled on the rising edge of sclk, MSB first. Each lane gives four 16-bit words. Lane sdo_a gives channels 1..4 and lane sdo_b gives channels 5..8. Channel n (1..8) appears at words[(n-1)*16 +: 16].
- R6: After cs_n is released, valid is high for exactly one cycle. All eight words are updated together in that cycle and held until the next valid.
- R7: first_data must be 1 for serial bits 0..15 of a frame and 0 for bits 16..63. Any other value sets frame_err, which stays set until reset. The frame is still delivered with valid.
- R8: If busy does not rise within TIMEOUT cycles after the conv_n pulse, or does not fall within TIMEOUT cycles after rising, timeout_err is set and stays set until reset. No readout takes place, and the block returns to idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Acquisition request, taken in idle only |
| busy | input | 1 | Converter busy indicator |
| first_data | input | 1 | Converter first-word indicator |
| sdo_a | input | 1 | Serial data lane A (channels 1..4) |
| sdo_b | input | 1 | Serial data lane B (channels 5..8) |
| conv_n | output | 1 | Conversion start, active low pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| words | output | 2*CH_PER_LANE*WORD_W | Eight channel words, channel 1 in the low bits |
| valid | output | 1 | One-cycle strobe when words are updated |
| frame_err | output | 1 | Sticky first-data shape error |
| timeout_err | output | 1 | Sticky busy handshake timeout |

## Verification
A bit counter that is wrong by one shows up as cs_n held low for more or fewer than 64 serial periods. It also rotates every channel word by one bit, which the first data comparison exposes as soon as the first frame ends. A state machine that skips the busy handshake lowers cs_n while busy is still high, which is visible within a few cycles of the conversion pulse. A stuck-clear error flag, or a timeout counter off by its limit, shows at the flags within TIMEOUT cycles of the condition.

// File: rtl/dual_lane_adc_reader.sv
module dual_lane_adc_reader #(
  parameter int CLK_DIV     = 4,
  parameter int CONV_LOW    = 4,
  parameter int TIMEOUT     = 1000,
  parameter int WORD_W      = 16,
  parameter int CH_PER_LANE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic first_data,
  input  logic sdo_a,
  input  logic sdo_b,
  output logic conv_n,
  output logic cs_n,
  output logic sclk,
  output logic [2*CH_PER_LANE*WORD_W-1:0] words,
  output logic valid,
  output logic frame_err,
  output logic timeout_err
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int FRAME = WORD_W * CH_PER_LANE;
  localparam int CW    = $clog2(TIMEOUT + CONV_LOW + CLK_DIV + 1);
  localparam int BW    = $clog2(FRAME + 1);

  typedef enum logic [2:0] {IDLE, CONV, WRISE, WFALL, READ, DONE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bcnt;
  logic [FRAME-1:0] sh_a, sh_b;
  logic [2*CH_PER_LANE*WORD_W-1:0] packed_w;

  wire tick      = (cnt == CW'(HALF - 1));
  wire cap       = (st == READ) && tick && !sclk;
  wire last      = (bcnt == BW'(FRAME - 1));
  wire fd_expect = (bcnt < BW'(WORD_W));
  wire to_hit    = (cnt == CW'(TIMEOUT - 1));

  assign conv_n = (st != CONV);
  assign cs_n   = (st != READ);

  for (genvar k = 0; k < CH_PER_LANE; k++) begin : g_pack
    assign packed_w[k*WORD_W +: WORD_W] =
      sh_a[FRAME-1-k*WORD_W -: WORD_W];
    assign packed_w[(k+CH_PER_LANE)*WORD_W +: WORD_W] =
      sh_b[FRAME-1-k*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      cnt         <= '0;
      bcnt        <= '0;
      sclk        <= 1'b1;
      sh_a        <= '0;
      sh_b        <= '0;
      words       <= '0;
      valid       <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        IDLE: begin
          cnt  <= '0;
          bcnt <= '0;
          sclk <= 1'b1;
          if (start) st <= CONV;
        end
        CONV: begin
          if (cnt == CW'(CONV_LOW - 1)) begin
            cnt <= '0;
            st  <= WRISE;
          end else cnt <= cnt + 1'b1;
        end
        WRISE: begin
          if (busy) begin
            cnt <= '0;
            st  <= WFALL;
          end else if (to_hit) begin
            timeout_err <= 1'b1;
            st          <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        WFALL: begin
          if (!busy) begin
            cnt <= '0;
            st  <= READ;
          end else if (to_hit) begin
            timeout_err <= 1'b1;
            st          <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        READ: begin
          if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
          end else cnt <= cnt + 1'b1;
          if (cap) begin
            sh_a <= {sh_a[FRAME-2:0], sdo_a};
            sh_b <= {sh_b[FRAME-2:0], sdo_b};
            bcnt <= bcnt + 1'b1;
            if (first_data != fd_expect) frame_err <= 1'b1;
            if (last) st <= DONE;
          end
        end
        DONE: begin
          words <= packed_w;
          valid <= 1'b1;
          st    <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module dual_lane_adc_reader_chk #(
  parameter int CONV_LOW    = 4,
  parameter int WORD_W      = 16,
  parameter int CH_PER_LANE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic conv_n,
  input logic cs_n,
  input logic sclk,
  input logic valid,
  input logic frame_err,
  input logic timeout_err
);
  localparam int FRAME = WORD_W * CH_PER_LANE;
  localparam int NW    = $clog2(FRAME + 2) + 1;
  localparam int LW    = $clog2(CONV_LOW + 2) + 1;

  logic [NW-1:0] nfall;
  logic [LW-1:0] lowc;
  logic          sclk_q, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfall  <= '0;
      lowc   <= '0;
      sclk_q <= 1'b1;
      armed  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!conv_n) nfall <= '0;
      else if (!cs_n && sclk_q && !sclk) nfall <= nfall + 1'b1;
      if (!conv_n) lowc <= (lowc == '1) ? lowc : lowc + 1'b1;
      else lowc <= '0;
      if (!conv_n) armed <= 1'b1;
      else if (valid) armed <= 1'b0;
    end
  end

  assert_conv_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> lowc == LW'(CONV_LOW));
  assert_cs_after_busy_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy) && armed);
  assert_frame_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> nfall == NW'(FRAME));
  assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> cs_n && $past(cs_n) && !$past(cs_n, 2));
  assert_frame_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  assert_timeout_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> cs_n && conv_n);
endmodule

bind dual_lane_adc_reader dual_lane_adc_reader_chk #(
  .CONV_LOW(CONV_LOW), .WORD_W(WORD_W), .CH_PER_LANE(CH_PER_LANE)
) chk_i (.*);

// File: tb/dual_lane_adc_reader_tb_top.sv
module dual_lane_adc_reader_tb_top;
  localparam int CLK_DIV = 4, CONV_LOW = 3, TIMEOUT = 40, W = 16, CPL = 4;

  logic clk = 0, rst_n = 0, start = 0, busy = 0;
  logic sdo_a, sdo_b, first_data;
  logic conv_n, cs_n, sclk, valid, frame_err, timeout_err;
  logic [2*CPL*W-1:0] words;

  dual_lane_adc_reader #(.CLK_DIV(CLK_DIV), .CONV_LOW(CONV_LOW), .TIMEOUT(TIMEOUT),
    .WORD_W(W), .CH_PER_LANE(CPL)) dut_i (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [63:0] fa = '0, fb = '0;
  int nfall = 0, fd_mode = 0, busy_mode = 0, rise_dly = 2, hold = 10;
  int bidx;
  assign bidx  = (nfall == 0) ? 0 : nfall - 1;
  assign sdo_a = fa[63 - bidx];
  assign sdo_b = fb[63 - bidx];
  always_comb
    case (fd_mode)
      0: first_data = (bidx < 16);
      1: first_data = (bidx < 17);
      2: first_data = ((bidx % 8) == 0);
      default: first_data = 1'b0;
    endcase

  always @(negedge sclk or negedge cs_n)
    if (!cs_n && sclk) nfall <= 0;
    else if (!cs_n) nfall <= nfall + 1;

  always begin
    wait (rst_n);
    @(negedge conv_n);
    @(posedge conv_n);
    repeat (rise_dly) @(posedge clk);
    if (busy_mode != 1) busy <= 1;
    repeat (hold) @(posedge clk);
    if (busy_mode != 2) busy <= 0;
  end

  int conv_low, conv_falls, cs_low, cs_falls, early, sfalls, idle_low, vcnt;
  logic conv_p = 1, cs_p = 1, sclk_p = 1;
  always @(negedge clk) begin
    cycles++;
    if (!conv_n) conv_low++;
    if (!conv_n && conv_p) conv_falls++;
    if (!cs_n) cs_low++;
    if (!cs_n && cs_p) begin cs_falls++; if (busy) early++; end
    if (!cs_n && sclk_p && !sclk) sfalls++;
    if (cs_n && !sclk && rst_n) idle_low++;
    if (valid) vcnt++;
    conv_p = conv_n; cs_p = cs_n; sclk_p = sclk;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int f, input int ch);
    if (f == 0) return 16'h0000;
    if (f == 1) return 16'hFFFF;
    if (f == 2) return 16'h8000 >> (ch * 2);
    return 16'((f * 40503 + ch * 4663) ^ (ch << (f % 12)));
  endfunction

  task automatic clr_mon();
    conv_low = 0; conv_falls = 0; cs_low = 0; cs_falls = 0;
    early = 0; sfalls = 0; vcnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; busy = 0; busy_mode = 0; fd_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_frame(input int f, input int fdm, input bit exp_fe, input bit extra);
    int n;
    fa = {wd(f,0), wd(f,1), wd(f,2), wd(f,3)};
    fb = {wd(f,4), wd(f,5), wd(f,6), wd(f,7)};
    fd_mode = fdm; rise_dly = 1 + f % 5; hold = 1 + (f * 7) % 30;
    clr_mon();
    pulse_start();
    if (extra) begin
      repeat (CONV_LOW + 2) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
      repeat (hold + 20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    n = 0;
    while (!valid && n < 2000) begin @(negedge clk); n++; end
    chk(valid, "R6 valid seen", valid, 1);
    for (int k = 0; k < 8; k++)
      chk(words[k*16 +: 16] == wd(f, k), $sformatf("R5 frame %0d ch%0d", f, k + 1),
          words[k*16 +: 16], wd(f, k));
    @(negedge clk);
    chk(vcnt == 1, "R6 one-cycle valid", vcnt, 1);
    chk(words[15:0] == wd(f, 0), "R6 words held", words[15:0], wd(f, 0));
    chk(conv_low == CONV_LOW, "R2 conv_n low width", conv_low, CONV_LOW);
    chk(conv_falls == 1, "R2 single conversion", conv_falls, 1);
    chk(cs_falls == 1 && early == 0, "R3 cs_n after busy low", early, 0);
    chk(cs_low == 64 * CLK_DIV, "R4 cs_n low cycles", cs_low, 64 * CLK_DIV);
    chk(sfalls == 64, "R4 sclk periods", sfalls, 64);
    chk(idle_low == 0, "R4 sclk idle high", idle_low, 0);
    chk(frame_err == exp_fe, "R7 frame_err", frame_err, exp_fe);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    idle_low = 0;
    @(negedge clk);
    chk(conv_n && cs_n && sclk && !valid, "R1 outputs in reset",
        {conv_n, cs_n, sclk, valid}, 4'b1110);
    chk(!frame_err && !timeout_err, "R1 flags in reset", {frame_err, timeout_err}, 0);
    do_reset();
    chk(conv_n && cs_n && sclk && !valid && !frame_err && !timeout_err,
        "R1 after reset", {conv_n, cs_n, sclk, valid, frame_err, timeout_err}, 6'b111000);

    for (int f = 0; f < 14; f++) run_frame(f, 0, 0, f == 5 || f == 9);

    // R8: busy never rises
    clr_mon(); busy_mode = 1;
    pulse_start();
    repeat (CONV_LOW + TIMEOUT - 4) @(negedge clk);
    chk(!timeout_err, "R8 no early timeout", timeout_err, 0);
    repeat (20) @(negedge clk);
    chk(timeout_err, "R8 timeout on missing rise", timeout_err, 1);
    chk(cs_falls == 0 && vcnt == 0, "R8 no readout", cs_falls + vcnt, 0);
    busy_mode = 0;
    run_frame(3, 0, 0, 0);
    chk(timeout_err, "R8 timeout sticky", timeout_err, 1);

    // R8: busy never falls
    do_reset();
    clr_mon(); busy_mode = 2; rise_dly = 2;
    pulse_start();
    repeat (TIMEOUT + 30) @(negedge clk);
    chk(timeout_err, "R8 timeout on missing fall", timeout_err, 1);
    chk(cs_falls == 0 && vcnt == 0, "R8 no readout after stuck busy", cs_falls + vcnt, 0);

    // R7: first_data shapes
    for (int m = 1; m < 4; m++) begin
      do_reset();
      chk(!frame_err, "R7 cleared by reset", frame_err, 0);
      run_frame(6 + m, m, 1, 0);
      run_frame(11, 0, 1, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule